// File: doc/BRIEF.md
# Programmable Counter/Timer with Receive Timeout

This block is a down-counter whose divisor is built from two preload bytes and which advances only on cycles where its counter clock enable is high. It runs in one of three ways. As a timer it produces a free-running square wave, typically used as a 16x baud clock. For that use the divisor is the input rate divided by sixteen times the baud rate, rounded to the nearest integer. As a counter it is a one-shot delay that raises a ready flag after the programmed number of ticks. As a receive timeout it is restarted by "character received" pulses from up to `NCH` receive channels. It raises the ready flag when the line has been quiet for a full divisor period.

Timeout operation is armed and disarmed per channel by on/off command strobes. While any channel has it armed, the timer/counter commands are ignored. Characters from every armed channel restart the one shared counter, so with two armed channels the flag rises only when both have been idle. The ready flag drives an interrupt output through a mask input.

Top module: `ctmr_top`

## Requirements
- R1: After reset `cnt_ready` = 0, `irq` = 0, `sq_out` = 1, the counter is stopped and timeout operation is disarmed on every channel.
- R2: The divisor N is `{preload_hi, preload_lo}` (upper byte in the high half). A value of 0 or 1 is treated as N = 2.
- R3: With no timeout armed, a `start_cmd` with `mode_sel` = 0 (timer) sets `sq_out` high. The output then stays high for ceil(N/2) enabled ticks and low for floor(N/2) enabled ticks, repeating. Each change is visible in the cycle after the tick that completes the phase.
- R4: In timer operation `cnt_ready` sets at the end of each full period, at the low-to-high change of `sq_out`.
- R5: With no timeout armed, a `start_cmd` with `mode_sel` = 1 (counter) clears `cnt_ready`. The flag sets on the Nth enabled tick after the start and then holds, with the count stopped.
- R6: With no timeout armed, `stop_cmd` halts the count and clears `cnt_ready`. `sq_out` holds its level. `stop_cmd` takes priority over a simultaneous `start_cmd`.
- R7: `irq` equals `cnt_ready` while `irq_mask` = 1 and is 0 while `irq_mask` = 0.
- R8: A `tout_on[c]` pulse arms timeout operation for channel c, clears `cnt_ready` and holds the counter stopped until an accepted character arrives.
- R9: While timeout is armed, an `rx_char[c]` pulse on an armed channel reloads N, clears `cnt_ready` and withdraws `irq`. If no further accepted character arrives, `cnt_ready` sets on the Nth enabled tick after the reload.
- R10: `rx_char` pulses on a channel whose timeout is not armed are ignored. With two channels armed, a character on either one restarts the shared count.
- R11: While any channel is armed, `start_cmd`, `stop_cmd` and `mode_sel` have no effect. A `tout_off[c]` pulse disarms channel c. Once no channel is armed, a running timeout count stops, `cnt_ready` keeps its value and the timer/counter commands act again.
- R12: On cycles with `tick_en` = 0 no count advances. A load (start or accepted character) in the same cycle as a tick takes the load, and counting begins on the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Counter clock enable, one tick per high cycle |
| preload_hi | input | WIDTH/2 | Upper divisor byte |
| preload_lo | input | WIDTH/2 | Lower divisor byte |
| mode_sel | input | 1 | 0 = timer (square wave), 1 = counter (one-shot) |
| start_cmd | input | 1 | Start strobe for timer/counter operation |
| stop_cmd | input | 1 | Stop strobe for timer/counter operation |
| rx_char | input | NCH | Per-channel character-received pulse |
| tout_on | input | NCH | Per-channel timeout arm strobe |
| tout_off | input | NCH | Per-channel timeout disarm strobe |
| irq_mask | input | 1 | Interrupt enable for the ready flag |
| sq_out | output | 1 | Square-wave clock output |
| cnt_ready | output | 1 | Counter-ready flag |
| irq | output | 1 | Masked interrupt |

## Verification
The bench builds the block with its defaults, WIDTH = 16 and NCH = 2. That gives two real receive channels, so the shared restart, the ignored unarmed channel and the both-idle rule can all be exercised. Preloads are kept small so that many periods fit in a short run. One preload of 0x0102 shows that the upper byte really weighs 256, and preloads of 0 and 1 reach the clamp to 2. Odd and even divisors, with the tick enable both held high and gated pseudo-randomly, cover the uneven phase split and the stalls between ticks.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;

    // What the shared down-counter is currently doing
    typedef enum logic [1:0] {
        MD_IDLE  = 2'd0,
        MD_TIMER = 2'd1,
        MD_COUNT = 2'd2,
        MD_TOUT  = 2'd3
    } run_mode_e;

    localparam logic SEL_TIMER = 1'b0;
    localparam logic SEL_COUNT = 1'b1;

endpackage

// File: rtl/ctmr_divsplit.sv
// Builds the divisor from the two preload bytes, clamps it to >= 2 and
// splits it into high and low phase lengths (odd divisors: longer high).
module ctmr_divsplit #(
    parameter int W = 16
) (
    input  logic [W/2-1:0] hi_byte,
    input  logic [W/2-1:0] lo_byte,
    output logic [W-1:0]   div,
    output logic [W-1:0]   hi_len,
    output logic [W-1:0]   lo_len
);
    logic [W-1:0] raw;

    always_comb begin
        raw    = {hi_byte, lo_byte};
        div    = (raw < W'(2)) ? W'(2) : raw;
        lo_len = div >> 1;
        hi_len = (div >> 1) + W'(div[0]);
    end
endmodule

// File: rtl/ctmr_tosel.sv
// Per-channel timeout arm flags and the shared restart request.
module ctmr_tosel #(
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] arm,
    input  logic [NCH-1:0] disarm,
    input  logic [NCH-1:0] rx,
    output logic [NCH-1:0] en,
    output logic           restart,
    output logic           active
);
    logic [NCH-1:0] en_d, en_q;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        always_comb begin
            en_d[c] = en_q[c];
            if (arm[c]) begin
                en_d[c] = 1'b1;
            end else if (disarm[c]) begin
                en_d[c] = 1'b0;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                en_q[c] <= 1'b0;
            end else begin
                en_q[c] <= en_d[c];
            end
        end
    end

    assign en      = en_q;
    assign restart = |(rx & en_q);
    assign active  = |en_q;
endmodule

// File: rtl/ctmr_top.sv
module ctmr_top
    import ctmr_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int NCH   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_en,
    input  logic [WIDTH/2-1:0] preload_hi,
    input  logic [WIDTH/2-1:0] preload_lo,
    input  logic               mode_sel,
    input  logic               start_cmd,
    input  logic               stop_cmd,
    input  logic [NCH-1:0]     rx_char,
    input  logic [NCH-1:0]     tout_on,
    input  logic [NCH-1:0]     tout_off,
    input  logic               irq_mask,
    output logic               sq_out,
    output logic               cnt_ready,
    output logic               irq
);
    localparam logic [WIDTH-1:0] CNT_ONE = WIDTH'(1);

    typedef struct packed {
        logic [WIDTH-1:0] cnt;
        logic             run;
        logic             rdy;
        logic             sq;
        run_mode_e        kind;
    } st_t;

    logic [WIDTH-1:0] div, hi_len, lo_len;
    logic [NCH-1:0]   to_en;
    logic             to_restart, to_active;
    st_t              s_d, s_q;

    ctmr_divsplit #(.W(WIDTH)) u_div (
        .hi_byte (preload_hi),
        .lo_byte (preload_lo),
        .div     (div),
        .hi_len  (hi_len),
        .lo_len  (lo_len)
    );

    ctmr_tosel #(.NCH(NCH)) u_tosel (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (tout_on),
        .disarm  (tout_off),
        .rx      (rx_char),
        .en      (to_en),
        .restart (to_restart),
        .active  (to_active)
    );

    always_comb begin
        s_d = s_q;
        if (!to_active) begin
            if (stop_cmd) begin
                s_d.run = 1'b0;
                s_d.rdy = 1'b0;
            end else if (start_cmd) begin
                s_d.run = 1'b1;
                s_d.rdy = 1'b0;
                if (mode_sel == SEL_TIMER) begin
                    s_d.kind = MD_TIMER;
                    s_d.cnt  = hi_len;
                    s_d.sq   = 1'b1;
                end else begin
                    s_d.kind = MD_COUNT;
                    s_d.cnt  = div;
                end
            end else if (s_q.run) begin
                if (s_q.kind == MD_TOUT || s_q.kind == MD_IDLE) begin
                    // timeout disarmed underneath a running count
                    s_d.run = 1'b0;
                end else if (tick_en) begin
                    if (s_q.cnt == CNT_ONE) begin
                        if (s_q.kind == MD_TIMER) begin
                            s_d.sq  = ~s_q.sq;
                            s_d.cnt = s_q.sq ? lo_len : hi_len;
                            if (!s_q.sq) begin
                                s_d.rdy = 1'b1;
                            end
                        end else begin
                            s_d.cnt = '0;
                            s_d.run = 1'b0;
                            s_d.rdy = 1'b1;
                        end
                    end else begin
                        s_d.cnt = s_q.cnt - CNT_ONE;
                    end
                end
            end
        end else if (s_q.run && tick_en && s_q.kind == MD_TOUT) begin
            if (s_q.cnt == CNT_ONE) begin
                s_d.cnt = '0;
                s_d.run = 1'b0;
                s_d.rdy = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt - CNT_ONE;
            end
        end

        if (|tout_on) begin
            s_d.run = 1'b0;
            s_d.rdy = 1'b0;
        end

        if (to_restart) begin
            s_d.kind = MD_TOUT;
            s_d.cnt  = div;
            s_d.run  = 1'b1;
            s_d.rdy  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{cnt: '0, run: 1'b0, rdy: 1'b0, sq: 1'b1, kind: MD_IDLE};
        end else begin
            s_q <= s_d;
        end
    end

    assign sq_out    = s_q.sq;
    assign cnt_ready = s_q.rdy;
    assign irq       = s_q.rdy & irq_mask;
endmodule

// File: rtl/ctmr_chk.sv
module ctmr_chk #(
    parameter int NCH = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic           tick_en,
    input logic           start_cmd,
    input logic           stop_cmd,
    input logic [NCH-1:0] rx_char,
    input logic [NCH-1:0] tout_on,
    input logic [NCH-1:0] to_en,
    input logic           irq_mask,
    input logic           sq_out,
    input logic           cnt_ready,
    input logic           irq
);
    // R7: a masked flag never reaches the interrupt pin
    a_r7_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_mask |-> !irq);

    // R12: the ready flag only rises after an enabled tick
    a_r12_ready_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cnt_ready) |-> $past(tick_en));

    // R12: the square wave moves only on a tick or a start
    a_r12_sq_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sq_out) |-> ($past(tick_en) || $past(start_cmd)));

    // R8: arming a channel clears the flag
    a_r8_arm_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (|tout_on) |=> !cnt_ready);

    // R9: an accepted character clears the flag
    a_r9_rx_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (|(rx_char & to_en)) |=> !cnt_ready);

    // R6: a stop outside timeout operation clears the flag
    a_r6_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_cmd && !(|to_en)) |=> !cnt_ready);
endmodule

bind ctmr_top ctmr_chk #(.NCH(NCH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .start_cmd (start_cmd),
    .stop_cmd  (stop_cmd),
    .rx_char   (rx_char),
    .tout_on   (tout_on),
    .to_en     (to_en),
    .irq_mask  (irq_mask),
    .sq_out    (sq_out),
    .cnt_ready (cnt_ready),
    .irq       (irq)
);

// File: tb/sim_ctmr_top.sv
`timescale 1ns/1ps
module sim_ctmr_top;
    localparam int W   = 16;
    localparam int HW  = W / 2;
    localparam int NCH = 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           tick_en = 1'b1;
    logic [HW-1:0]  preload_hi = '0;
    logic [HW-1:0]  preload_lo = 8'd5;
    logic           mode_sel = 1'b0;
    logic           start_cmd = 1'b0;
    logic           stop_cmd = 1'b0;
    logic [NCH-1:0] rx_char = '0;
    logic [NCH-1:0] tout_on = '0;
    logic [NCH-1:0] tout_off = '0;
    logic           irq_mask = 1'b0;
    logic           sq_out, cnt_ready, irq;

    ctmr_top #(.WIDTH(W), .NCH(NCH)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .preload_hi(preload_hi), .preload_lo(preload_lo),
        .mode_sel(mode_sel), .start_cmd(start_cmd), .stop_cmd(stop_cmd),
        .rx_char(rx_char), .tout_on(tout_on), .tout_off(tout_off),
        .irq_mask(irq_mask), .sq_out(sq_out), .cnt_ready(cnt_ready), .irq(irq)
    );

    always #2.5 clk = ~clk;

    int    compared = 0;
    int    mismatched = 0;
    int    cycles = 0;
    bit    done = 0;
    bit    checking = 0;
    string tag = "R1";

    // ---------------- reference model ----------------
    // kinds: 0 idle, 1 timer, 2 counter, 3 timeout
    int m_kind = 0, m_run = 0, m_rdy = 0, m_sq = 1, m_pos = 0, m_rem = 0;
    int m_arm [NCH];

    function automatic int divisor();
        int n;
        n = int'(preload_hi) * 256 + int'(preload_lo);
        if (n < 2) n = 2;
        return n;
    endfunction

    initial foreach (m_arm[i]) m_arm[i] = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_kind = 0; m_run = 0; m_rdy = 0; m_sq = 1; m_pos = 0; m_rem = 0;
            foreach (m_arm[i]) m_arm[i] = 0;
        end else begin
            int n, armed, hit;
            n = divisor();
            armed = 0;
            hit = 0;
            foreach (m_arm[i]) begin
                if (m_arm[i] != 0) armed = 1;
                if (m_arm[i] != 0 && rx_char[i]) hit = 1;
            end
            if (armed == 0) begin
                if (stop_cmd) begin
                    m_run = 0; m_rdy = 0;
                end else if (start_cmd) begin
                    m_run = 1; m_rdy = 0;
                    if (!mode_sel) begin m_kind = 1; m_pos = 0; m_sq = 1; end
                    else begin m_kind = 2; m_rem = n; end
                end else if (m_run != 0) begin
                    if (m_kind == 3 || m_kind == 0) m_run = 0;
                    else if (tick_en) begin
                        if (m_kind == 1) begin
                            m_pos = (m_pos + 1) % n;
                            m_sq  = (m_pos < (n + 1) / 2) ? 1 : 0;
                            if (m_pos == 0) m_rdy = 1;
                        end else begin
                            m_rem--;
                            if (m_rem == 0) begin m_run = 0; m_rdy = 1; end
                        end
                    end
                end
            end else if (m_run != 0 && tick_en && m_kind == 3) begin
                m_rem--;
                if (m_rem == 0) begin m_run = 0; m_rdy = 1; end
            end
            if (tout_on != 0) begin m_run = 0; m_rdy = 0; end
            if (hit != 0) begin m_kind = 3; m_rem = n; m_run = 1; m_rdy = 0; end
            foreach (m_arm[i]) begin
                if (tout_on[i]) m_arm[i] = 1;
                else if (tout_off[i]) m_arm[i] = 0;
            end
        end
    end

    // ---------------- comparison, away from the active edge ----------------
    always @(negedge clk) begin
        if (checking && !done) begin
            logic e_sq, e_rdy, e_irq;
            e_sq  = (m_sq != 0);
            e_rdy = (m_rdy != 0);
            e_irq = e_rdy & irq_mask;
            compared++;
            if (sq_out !== e_sq || cnt_ready !== e_rdy || irq !== e_irq) begin
                mismatched++;
                $display("FAIL %s t=%0t sq/ready/irq got %b%b%b exp %b%b%b",
                         tag, $time, sq_out, cnt_ready, irq, e_sq, e_rdy, e_irq);
            end
        end
    end

    // ---------------- tick enable source ----------------
    bit         tick_rand = 0;
    logic [7:0] lfsr = 8'hA5;
    always @(negedge clk) begin
        #2;
        lfsr    = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        tick_en = tick_rand ? lfsr[0] : 1'b1;
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            mismatched++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wait_cyc(input int n);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic set_div(input int v);
        preload_hi = HW'(v / 256);
        preload_lo = HW'(v % 256);
    endtask

    task automatic do_start(input logic sel);
        mode_sel = sel; start_cmd = 1'b1; wait_cyc(1); start_cmd = 1'b0;
    endtask

    task automatic do_stop();
        stop_cmd = 1'b1; wait_cyc(1); stop_cmd = 1'b0;
    endtask

    task automatic pulse_rx(input int ch);
        rx_char[ch] = 1'b1; wait_cyc(1); rx_char[ch] = 1'b0;
    endtask

    task automatic arm(input int ch);
        tout_on[ch] = 1'b1; wait_cyc(1); tout_on[ch] = 1'b0;
    endtask

    task automatic disarm(input int ch);
        tout_off[ch] = 1'b1; wait_cyc(1); tout_off[ch] = 1'b0;
    endtask

    initial begin
        tag = "R1";
        wait_cyc(3);
        checking = 1;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(4);

        tag = "R3";  // odd divisor, uneven phases
        irq_mask = 1'b1;
        set_div(5);
        do_start(1'b0);
        wait_cyc(30);
        tag = "R4";  // even divisor, ready at each period end
        do_stop();
        set_div(4);
        do_start(1'b0);
        wait_cyc(20);

        tag = "R12"; // gated ticks, load coincident with ticks
        tick_rand = 1;
        set_div(7);
        do_start(1'b0);
        wait_cyc(60);
        do_start(1'b1);
        wait_cyc(30);
        tick_rand = 0;

        tag = "R6";  // stop mid timer, mid counter, stop beats start
        set_div(9);
        do_start(1'b0);
        wait_cyc(6);
        do_stop();
        wait_cyc(8);
        do_start(1'b1);
        wait_cyc(4);
        do_stop();
        wait_cyc(12);
        start_cmd = 1'b1; stop_cmd = 1'b1; wait_cyc(1);
        start_cmd = 1'b0; stop_cmd = 1'b0;
        wait_cyc(12);

        tag = "R5";  // one-shot counter, holds afterwards
        set_div(6);
        do_start(1'b1);
        wait_cyc(15);

        tag = "R7";  // mask toggling over a set flag
        irq_mask = 1'b0; wait_cyc(3);
        irq_mask = 1'b1; wait_cyc(3);
        irq_mask = 1'b0;
        do_start(1'b1);
        wait_cyc(10);
        irq_mask = 1'b1;

        tag = "R2";  // clamp of 0 and 1, upper byte weight
        set_div(0);
        do_start(1'b0);
        wait_cyc(10);
        set_div(1);
        do_start(1'b1);
        wait_cyc(6);
        set_div(258);
        do_start(1'b1);
        wait_cyc(270);

        tag = "R8";  // arm clears ready and holds the count
        set_div(10);
        arm(0);
        wait_cyc(25);

        tag = "R9";  // restarts, then a quiet gap
        for (int k = 0; k < 4; k++) begin
            pulse_rx(0);
            wait_cyc(6);
        end
        wait_cyc(15);
        pulse_rx(0);      // character after the timeout withdraws irq
        wait_cyc(4);

        tag = "R10"; // unarmed channel ignored, then both armed
        wait_cyc(10);
        for (int k = 0; k < 3; k++) begin
            pulse_rx(1);
            wait_cyc(5);
        end
        wait_cyc(6);
        arm(1);
        pulse_rx(1);
        wait_cyc(6);
        pulse_rx(0);
        wait_cyc(6);
        pulse_rx(1);
        wait_cyc(18);

        tag = "R11"; // timer commands ignored while armed, then disarm
        pulse_rx(0);
        do_start(1'b0);
        wait_cyc(3);
        do_stop();
        wait_cyc(14);
        disarm(0);
        pulse_rx(0);      // channel 0 now disarmed: ignored
        wait_cyc(4);
        pulse_rx(1);
        wait_cyc(3);
        disarm(1);        // stops a running timeout count
        wait_cyc(15);
        set_div(3);
        do_start(1'b0);
        wait_cyc(12);
        do_start(1'b1);
        wait_cyc(8);

        finish_run();
    end
endmodule